// File: doc/BRIEF.md
# Tuning Word History Averager

This block watches the stream of frequency tuning words produced by a loop filter and keeps a history value: the mean of the words sampled over a programmable interval counted in millisecond ticks. When an interval closes, the block sums the valid samples of that interval and divides the sum by their count. The divider is sequential and takes several cycles. It then stores the quotient as the new history word and raises a one-cycle update strobe. Each interval starts with an empty accumulator, so a stored value never mixes samples from two intervals.

A restart begins a fresh interval. It comes from a software clear or from a switch to another reference. A clear always wipes the stored history. A reference switch keeps the stored value only when the persistent-history input is high. Long intervals would leave the block with no history for a long time, so the first interval after the history has been wiped can also produce up to seven early averages. These fall at power-of-two fractions of the interval.

The control FSM has three states. ACCUM is the idle state: samples are accumulated and interval marks are watched. DIVIDE waits for the divider. STORE lasts one cycle and drives the update strobe. Its transitions are as follows. *accept* moves ACCUM to DIVIDE: a mark is reached with a nonzero sample count and there is no restart. *quotient ready* moves DIVIDE to STORE. *strobe done* always moves STORE to ACCUM. *restart* moves any state to ACCUM and abandons a division in progress.

Top module: `twh_history_avg`

## Requirements
- R1: After reset, hist_valid is 0, hist_word is 0 and hist_update is 0.
- R2: A stored full-interval value is floor(sum/count) over the valid samples of that interval only. A sample presented in the same cycle as the closing tick counts toward the closing interval. The accumulator restarts at every full boundary.
- R3: A full boundary occurs on the tick that brings the tick count since the last boundary or restart to interval_ms. An interval_ms of 0 behaves as 1.
- R4: hist_update is high for exactly one cycle. In that cycle hist_word already shows the new value. The strobe comes WORD_W+CNT_W+2 cycles after the cycle holding the closing tick.
- R5: While no history exists, the first interval also stores at tick counts interval>>s, for s = 1..inc_k, but only where that count is nonzero and different from the full length. Each early value averages all samples since the interval started.
- R6: Once the first full boundary has passed, values are stored only at full boundaries.
- R7: A boundary whose interval held no valid samples stores nothing, gives no strobe and leaves hist_word and hist_valid unchanged.
- R8: sw_clear sets hist_valid and hist_word to 0 from the next cycle. It discards the accumulator, including the sample of that cycle, and abandons a pending result. The next interval is treated as a first interval.
- R9: ref_switch with persist_en low has the same effect as sw_clear.
- R10: ref_switch with persist_en high keeps hist_word and hist_valid and restarts accumulation. Early averages then apply only if no history existed.
- R11: A boundary that falls between an accepted boundary and its update strobe (inclusive) stores nothing. It still restarts the accumulator when it is a full boundary.
- R12: hist_valid rises together with the first stored value and stays high until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tw_in | input | WORD_W | Tuning word sample |
| tw_valid | input | 1 | tw_in is a sample this cycle |
| tick_ms | input | 1 | One-cycle millisecond tick |
| interval_ms | input | IVL_W | Averaging interval in ticks |
| inc_k | input | K_W | Number of early averages in a first interval |
| persist_en | input | 1 | Keep history across a reference switch |
| sw_clear | input | 1 | Wipe history and restart |
| ref_switch | input | 1 | Reference changed; restart accumulation |
| hist_word | output | WORD_W | Stored average |
| hist_valid | output | 1 | A stored average exists |
| hist_update | output | 1 | One-cycle strobe on each new store |

## Verification
Several sample patterns are applied, and each separates a different class of fault.

- Dense pseudo-random samples over short intervals show whether the accumulator is reset at the right boundary and whether the sample on the closing tick is counted.
- An interval setting of zero exposes any missing substitution of 1.
- Sparse samples over a 20-tick first interval with three early marks tell cumulative early averages apart from per-segment averages, and show whether the early marks stop after the first interval.
- A run with no samples separates "store nothing" from "store zero".
- Ticks closer together than the divide latency show whether boundaries are dropped while the block is busy.
- Clears and switches with persistence on and off, one of them issued in the middle of a division, test the keep, wipe and abandon rules.

// File: rtl/twh_pkg.sv
package twh_pkg;

    typedef enum logic [1:0] {
        ST_ACCUM,
        ST_DIVIDE,
        ST_STORE
    } twh_state_e;

endpackage

// File: rtl/twh_interval_timer.sv
module twh_interval_timer #(
    parameter int IVL_W = 24,
    parameter int K_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [IVL_W-1:0] interval_ms,
    input  logic [K_W-1:0]   inc_k,
    input  logic             first_pass,
    output logic             full_hit,
    output logic             inc_hit
);
    localparam int KMAX = (1 << K_W) - 1;

    logic [IVL_W-1:0] elapsed_q;
    logic [IVL_W-1:0] el_next;
    logic [IVL_W-1:0] t_eff;
    logic [KMAX:1]    mark_hit;

    assign t_eff   = (interval_ms == '0) ? IVL_W'(1) : interval_ms;
    assign el_next = elapsed_q + IVL_W'(1);

    // one comparator per possible early mark: interval >> s
    for (genvar s = 1; s <= KMAX; s++) begin : g_mark
        assign mark_hit[s] = (inc_k >= K_W'(s)) && ((t_eff >> s) == el_next);
    end

    always_comb begin
        full_hit = tick && (el_next >= t_eff);
        inc_hit  = tick && first_pass && !full_hit && (|mark_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (restart || full_hit) begin
            elapsed_q <= '0;
        end else if (tick) begin
            elapsed_q <= el_next;
        end
    end

endmodule

// File: rtl/twh_accumulator.sv
module twh_accumulator #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int ACC_W = WORD_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              full_hit,
    input  logic [WORD_W-1:0] sample,
    input  logic              sample_valid,
    output logic [ACC_W-1:0]  sum_next,
    output logic [CNT_W-1:0]  cnt_next
);
    logic [ACC_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    // a saturated count stops accumulation, keeping sum/count consistent
    assign take     = sample_valid && (cnt_q != '1);
    assign sum_next = sum_q + (take ? {{CNT_W{1'b0}}, sample} : '0);
    assign cnt_next = cnt_q + CNT_W'(take);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (restart || full_hit) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else begin
            sum_q <= sum_next;
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/twh_seq_divider.sv
module twh_seq_divider #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 16,
    parameter int OUT_W = 32,
    localparam int IT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [OUT_W-1:0] quot,
    output logic             done
);
    logic             busy_q;
    logic [IT_W-1:0]  iter_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             ge;

    // restoring division, one quotient bit per cycle
    assign trial = {rem_q, quo_q[NUM_W-1]};
    assign ge    = trial >= {1'b0, den_q};
    assign diff  = trial - {1'b0, den_q};
    assign quot  = quo_q[OUT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done   <= 1'b0;
            iter_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
            end else if (start) begin
                busy_q <= 1'b1;
                iter_q <= IT_W'(NUM_W);
                rem_q  <= '0;
                den_q  <= denom;
                quo_q  <= numer;
            end else if (busy_q) begin
                rem_q  <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo_q  <= {quo_q[NUM_W-2:0], ge};
                iter_q <= iter_q - IT_W'(1);
                if (iter_q == IT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/twh_history_avg.sv
module twh_history_avg
    import twh_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    parameter int IVL_W  = 24,
    parameter int K_W    = 3,
    localparam int ACC_W = WORD_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tw_in,
    input  logic              tw_valid,
    input  logic              tick_ms,
    input  logic [IVL_W-1:0]  interval_ms,
    input  logic [K_W-1:0]    inc_k,
    input  logic              persist_en,
    input  logic              sw_clear,
    input  logic              ref_switch,
    output logic [WORD_W-1:0] hist_word,
    output logic              hist_valid,
    output logic              hist_update
);
    twh_state_e        state_q, state_d;
    logic              restart;
    logic              keep_hist;
    logic              first_pass_q;
    logic              full_hit;
    logic              inc_hit;
    logic              accept;
    logic [ACC_W-1:0]  sum_next;
    logic [CNT_W-1:0]  cnt_next;
    logic [WORD_W-1:0] quot;
    logic              div_done;

    assign restart   = sw_clear || ref_switch;
    assign keep_hist = ref_switch && !sw_clear && persist_en && hist_valid;
    assign accept    = (state_q == ST_ACCUM) && (full_hit || inc_hit)
                       && (cnt_next != '0) && !restart;

    twh_interval_timer #(.IVL_W(IVL_W), .K_W(K_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .tick        (tick_ms),
        .interval_ms (interval_ms),
        .inc_k       (inc_k),
        .first_pass  (first_pass_q),
        .full_hit    (full_hit),
        .inc_hit     (inc_hit)
    );

    twh_accumulator #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .full_hit     (full_hit),
        .sample       (tw_in),
        .sample_valid (tw_valid),
        .sum_next     (sum_next),
        .cnt_next     (cnt_next)
    );

    twh_seq_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W), .OUT_W(WORD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .abort (restart),
        .numer (sum_next),
        .denom (cnt_next),
        .quot  (quot),
        .done  (div_done)
    );

    // first-interval flag: set whenever history is absent at a restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_pass_q <= 1'b1;
        end else if (restart) begin
            first_pass_q <= !keep_hist;
        end else if (full_hit) begin
            first_pass_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM:  if (accept)   state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_STORE;
            ST_STORE:                state_d = ST_ACCUM;
            default:                 state_d = ST_ACCUM;
        endcase
        if (restart) state_d = ST_ACCUM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACCUM;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_word  <= '0;
            hist_valid <= 1'b0;
        end else if (restart) begin
            if (!keep_hist) begin
                hist_word  <= '0;
                hist_valid <= 1'b0;
            end
        end else if (state_q == ST_DIVIDE && div_done) begin
            hist_word  <= quot;
            hist_valid <= 1'b1;
        end
    end

    assign hist_update = (state_q == ST_STORE);

endmodule

// File: rtl/twh_history_avg_chk.sv
module twh_history_avg_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              persist_en,
    input logic              sw_clear,
    input logic              ref_switch,
    input logic [WORD_W-1:0] hist_word,
    input logic              hist_valid,
    input logic              hist_update
);
    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_update |=> !hist_update); // R4

    AST_UPDATE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hist_update |-> hist_valid); // R12

    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hist_update |-> ($stable(hist_word) || $past(sw_clear) || $past(ref_switch))); // R6

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (!hist_valid && !hist_update && hist_word == '0)); // R8

    AST_SWITCH_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_switch && !persist_en) |=> !hist_valid); // R9

    AST_SWITCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_switch && persist_en && !sw_clear && hist_valid)
        |=> (hist_valid && $stable(hist_word))); // R10

endmodule

bind twh_history_avg twh_history_avg_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .persist_en  (persist_en),
    .sw_clear    (sw_clear),
    .ref_switch  (ref_switch),
    .hist_word   (hist_word),
    .hist_valid  (hist_valid),
    .hist_update (hist_update)
);

// File: tb/twh_history_avg_tb_top.sv
module twh_history_avg_tb_top;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int IVL_W  = 24;
    localparam int K_W    = 3;
    localparam int LAT    = WORD_W + CNT_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] tw_in = '0;
    logic              tw_valid = 1'b0;
    logic              tick_ms = 1'b0;
    logic [IVL_W-1:0]  interval_ms = 24'd4;
    logic [K_W-1:0]    inc_k = '0;
    logic              persist_en = 1'b0;
    logic              sw_clear = 1'b0;
    logic              ref_switch = 1'b0;
    logic [WORD_W-1:0] hist_word;
    logic              hist_valid;
    logic              hist_update;

    always #4 clk = ~clk;

    twh_history_avg dut_i (
        .clk(clk), .rst_n(rst_n), .tw_in(tw_in), .tw_valid(tw_valid),
        .tick_ms(tick_ms), .interval_ms(interval_ms), .inc_k(inc_k),
        .persist_en(persist_en), .sw_clear(sw_clear), .ref_switch(ref_switch),
        .hist_word(hist_word), .hist_valid(hist_valid), .hist_update(hist_update)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    upd_seen = 0;
    int    wd = 0;
    bit    done_run = 0;
    string cur_req = "R1";
    int    sample_mode = 0;
    int    drv_cnt = 0;
    longint unsigned lfsr = 64'd12345;

    // ---------------- reference model ----------------
    longint m_sum, m_cnt, m_el, m_word, m_last_due, m_cyc;
    bit     m_first, m_valid, m_upd;
    longint due_q[$];
    longint val_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sum = 0; m_cnt = 0; m_el = 0; m_word = 0; m_cyc = 0;
            m_first = 1; m_valid = 0; m_upd = 0; m_last_due = -1000;
            due_q.delete(); val_q.delete();
        end else begin
            longint s2, c2, el2, t;
            bit keep, full, inter;
            if (sw_clear || ref_switch) begin
                keep = ref_switch && !sw_clear && persist_en && m_valid;
                due_q.delete(); val_q.delete();
                m_last_due = -1000;
                if (!keep) begin m_valid = 0; m_word = 0; end
                m_first = !keep;
                m_sum = 0; m_cnt = 0; m_el = 0;
            end else begin
                s2 = m_sum; c2 = m_cnt;
                if (tw_valid && m_cnt < 65535) begin s2 += tw_in; c2 += 1; end
                if (tick_ms) begin
                    el2 = m_el + 1;
                    t = (interval_ms == 0) ? 1 : interval_ms;
                    full = (el2 >= t);
                    inter = 0;
                    if (!full && m_first)
                        for (int s = 1; s <= inc_k; s++)
                            if ((t >> s) == el2) inter = 1;
                    if ((full || inter) && c2 > 0 && due_q.size() == 0
                        && m_last_due < m_cyc) begin
                        due_q.push_back(m_cyc + LAT);
                        val_q.push_back(s2 / c2);
                        m_last_due = m_cyc + LAT;
                    end
                    if (full) begin
                        m_sum = 0; m_cnt = 0; m_el = 0; m_first = 0;
                    end else begin
                        m_sum = s2; m_cnt = c2; m_el = el2;
                    end
                end else begin
                    m_sum = s2; m_cnt = c2;
                end
            end
            m_upd = 0;
            if (due_q.size() > 0 && due_q[0] == m_cyc + 1) begin
                m_upd = 1; m_word = val_q[0]; m_valid = 1;
                void'(due_q.pop_front()); void'(val_q.pop_front());
            end
            m_cyc++;
        end
    end

    task automatic chk(string req, bit ok, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            if (hist_update) upd_seen++;
            n_checks++;
            if (hist_update !== m_upd || hist_valid !== m_valid
                || hist_word !== WORD_W'(m_word)) begin
                n_fail++;
                $display("FAIL %s cycle %0d actual upd/valid/word=%0b/%0b/%0d expected=%0b/%0b/%0d",
                         cur_req, m_cyc, hist_update, hist_valid, hist_word,
                         m_upd, m_valid, m_word[WORD_W-1:0]);
            end
        end
    end

    // sample driver: 0 none, 1 every cycle, 2 every third cycle
    always @(negedge clk) begin
        lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
        drv_cnt++;
        tw_in    <= lfsr[47:16];
        tw_valid <= (sample_mode == 1) || (sample_mode == 2 && drv_cnt % 3 == 0);
    end

    task automatic run_ticks(int period, int count);
        for (int i = 0; i < count; i++) begin
            repeat (period - 1) @(negedge clk);
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (LAT + 6) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); sw_clear = 1'b1;
        @(negedge clk); sw_clear = 1'b0;
    endtask

    task automatic pulse_switch();
        @(negedge clk); ref_switch = 1'b1;
        @(negedge clk); ref_switch = 1'b0;
    endtask

    task automatic finish_run();
        done_run = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done_run) begin
            chk("watchdog", 0, wd, 150000);
            finish_run();
        end
    end

    logic [WORD_W-1:0] saved_word;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", hist_valid == 0, hist_valid, 0);
        chk("R1", hist_word == 0, hist_word, 0);
        chk("R1", hist_update == 0, hist_update, 0);
        rst_n = 1'b1;

        // R2 / R3: dense samples, interval of 4 ticks
        cur_req = "R2"; sample_mode = 1; interval_ms = 24'd4; inc_k = 0;
        upd_seen = 0;
        run_ticks(64, 12); settle();
        chk("R2", upd_seen == 3, upd_seen, 3);
        chk("R12", hist_valid == 1, hist_valid, 1);

        // R3: interval 0 acts as 1
        cur_req = "R3"; interval_ms = '0; upd_seen = 0;
        run_ticks(64, 4); settle();
        chk("R3", upd_seen == 4, upd_seen, 4);

        // R8: software clear
        cur_req = "R8";
        pulse_clear();
        chk("R8", hist_valid == 0, hist_valid, 0);
        chk("R8", hist_word == 0, hist_word, 0);

        // R5 / R6: sparse samples, early marks 2,5,10 then 20 and 40
        cur_req = "R5"; sample_mode = 2; interval_ms = 24'd20; inc_k = 3'd3;
        upd_seen = 0;
        run_ticks(64, 45); settle();
        chk("R5", upd_seen == 5, upd_seen, 5);
        cur_req = "R6";

        // R7: no samples, nothing stored
        cur_req = "R7";
        pulse_clear();
        sample_mode = 0; interval_ms = 24'd3; upd_seen = 0;
        run_ticks(64, 6); settle();
        chk("R7", upd_seen == 0, upd_seen, 0);
        chk("R7", hist_valid == 0, hist_valid, 0);

        // R10: persistent switch keeps history, no early marks afterwards
        cur_req = "R10"; sample_mode = 1; interval_ms = 24'd2; inc_k = 0;
        run_ticks(64, 2); settle();
        saved_word = hist_word;
        persist_en = 1'b1; inc_k = 3'd2; interval_ms = 24'd8;
        pulse_switch();
        chk("R10", hist_valid == 1, hist_valid, 1);
        chk("R10", hist_word == saved_word, hist_word, saved_word);
        upd_seen = 0;
        run_ticks(64, 8); settle();
        chk("R10", upd_seen == 1, upd_seen, 1);

        // R9: non-persistent switch wipes history
        cur_req = "R9"; persist_en = 1'b0;
        pulse_switch();
        chk("R9", hist_valid == 0, hist_valid, 0);

        // R11: boundaries closer than the divide latency are dropped
        cur_req = "R11"; interval_ms = 24'd1; inc_k = 0; upd_seen = 0;
        run_ticks(20, 9); settle();
        chk("R11", upd_seen == 3, upd_seen, 3);

        // R8: clear during a division abandons the pending result
        cur_req = "R8"; upd_seen = 0;
        pulse_clear();
        run_ticks(64, 1);
        repeat (10) @(negedge clk);
        pulse_clear();
        settle();
        chk("R8", upd_seen == 0, upd_seen, 0);
        chk("R4", hist_valid == 0, hist_valid, 0);

        finish_run();
    end

endmodule